// File: doc/BRIEF.md
# Walking-Ones Data Line Tester

This block checks the data lines between on-chip logic and a simple synchronous single-port memory. After a start pulse it writes a word with exactly one bit set to one fixed address, reads that address back and compares the result. Only then does it move the set bit up by one position. It repeats this until every data line has carried the single one. Because every access goes to the same location, an address line fault cannot appear as a data line fault.

Each compare folds the difference between the written word and the read word into a sticky per-bit error mask. A bit that reads 0 where the 1 was written shows a line stuck low. Extra ones next to the walking bit show lines shorted together. Both kinds of fault stay visible in the mask. The block also records the first pattern that failed. When the last compare is done it raises a one-cycle done flag, and the pass flag can be read during that cycle. The block reports mismatches only. It does not try to tell what kind of fault caused them.

Top module: `walk1_tester`

## Requirements
- R1: Each run issues exactly DATA_W writes. Each write word has exactly one bit set, and the k-th write (k counted from 0) carries the value 1 << k.
- R2: Every write and every read of a run presents the address TEST_ADDR.
- R3: Each write is followed by exactly one read before the next write. Write enable and read enable are never high in the same cycle.
- R4: Read data is sampled exactly RD_LAT cycles after the cycle in which read enable is high. Any other cycle's read data has no effect on the result.
- R5: At done, the error mask equals the bitwise OR, over all patterns of the run, of the written word XOR the read-back word.
- R6: The fail-valid output is 1 at done if and only if some pattern mismatched. In that case the fail-pattern output holds the first mismatching written word, which is one-hot. Otherwise both outputs are 0.
- R7: Done is high for exactly one cycle. That cycle begins DATA_W*(RD_LAT+2) rising edges after the edge that samples start. During that cycle, pass is 1 exactly when the error mask is zero.
- R8: A start pulse that arrives while a run is in progress is ignored. The run neither restarts nor changes its timing.
- R9: A start accepted after done clears the error mask and the first-failure record before the new run.
- R10: While reset is low and right after it, write enable, read enable, done, error mask and fail-valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | DATA_W | Memory read data, valid RD_LAT cycles after read enable |
| done_o | output | 1 | One-cycle pulse after the last compare |
| pass_o | output | 1 | No mismatch seen; valid while done is high |
| err_mask_o | output | DATA_W | Sticky OR of per-pattern mismatches |
| fail_valid_o | output | 1 | A first failing pattern has been recorded |
| fail_pattern_o | output | DATA_W | First written word that mismatched |

## Verification
The bench sweeps a fault-free memory, every single data line stuck low, every line stuck high, and every adjacent pair of lines wired-OR shorted. A stuck-low line shows up as a single mask bit on exactly one pattern. A stuck-high line shows up on every other pattern. A short shows up as a two-bit mask whose first failure is the lower line of the pair. The model drives a garbage value on the read bus outside the sampled cycle, so a wrong read latency gives a mask that differs from the arithmetic prediction. A start pulse in the middle of a run, and fault-free runs that follow faulty runs, check that a start during a run is ignored and that a start after done clears the mask and the first-failure record.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_WAIT  = 2'd3
    } wt_state_e;

endpackage

// File: rtl/wt_onehot_gen.sv
module wt_onehot_gen #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] pat_o
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign pat_o[g] = (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/wt_rd_pipe.sv
module wt_rd_pipe #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic re_i,
    output logic vld_o
);
    logic [RD_LAT-1:0] sh_d, sh_q;

    if (RD_LAT == 1) begin : g_one
        always_comb sh_d = re_i;
    end else begin : g_many
        always_comb sh_d = {sh_q[RD_LAT-2:0], re_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign vld_o = sh_q[RD_LAT-1];
endmodule

// File: rtl/wt_err_accum.sv
module wt_err_accum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              cmp_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] act_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              first_vld_o,
    output logic [DATA_W-1:0] first_pat_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              fvld;
        logic [DATA_W-1:0] fpat;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [DATA_W-1:0] diff;

    always_comb begin
        diff  = exp_i ^ act_i;
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (cmp_i) begin
            acc_d.mask = acc_q.mask | diff;
            if ((|diff) && !acc_q.fvld) begin
                acc_d.fvld = 1'b1;
                acc_d.fpat = exp_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign mask_o      = acc_q.mask;
    assign first_vld_o = acc_q.fvld;
    assign first_pat_o = acc_q.fpat;
endmodule

// File: rtl/walk1_tester.sv
module walk1_tester #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h5A,
    parameter int                RD_LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic              pass_o,
    output logic [DATA_W-1:0] err_mask_o,
    output logic              fail_valid_o,
    output logic [DATA_W-1:0] fail_pattern_o
);
    import wt_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        wt_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DATA_W-1:0] pat;
    logic              rd_vld;
    logic              clr;
    logic              cmp;

    wt_onehot_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_gen (
        .idx_i (ctl_q.idx),
        .pat_o (pat)
    );

    wt_rd_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .re_i  (mem_re_o),
        .vld_o (rd_vld)
    );

    wt_err_accum #(.DATA_W(DATA_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .cmp_i       (cmp),
        .exp_i       (pat),
        .act_i       (mem_rdata_i),
        .mask_o      (err_mask_o),
        .first_vld_o (fail_valid_o),
        .first_pat_o (fail_pattern_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clr        = 1'b0;
        cmp        = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    clr        = 1'b1;
                    ctl_d.st   = ST_WRITE;
                    ctl_d.idx  = '0;
                    ctl_d.addr = TEST_ADDR;
                end
            end
            ST_WRITE: ctl_d.st = ST_READ;
            ST_READ:  ctl_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_vld) begin
                    cmp = 1'b1;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st  = ST_WRITE;
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, idx: '0, addr: '0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign mem_addr_o  = ctl_q.addr;
    assign mem_wdata_o = (ctl_q.st == ST_WRITE) ? pat : '0;
    assign mem_we_o    = (ctl_q.st == ST_WRITE);
    assign mem_re_o    = (ctl_q.st == ST_READ);
    assign done_o      = ctl_q.done;
    assign pass_o      = (err_mask_o == '0);
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 8'h5A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              done_o,
    input logic [DATA_W-1:0] err_mask_o,
    input logic              fail_valid_o,
    input logic [DATA_W-1:0] fail_pattern_o
);
    AST_ONEHOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($countones(mem_wdata_o) == 1)); // R1
    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (mem_addr_o == TEST_ADDR)); // R2
    AST_NO_WE_AND_RE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R3
    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> mem_re_o); // R3
    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (($past(err_mask_o) & ~err_mask_o) == '0)); // R5
    AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid_o |-> ($countones(fail_pattern_o) == 1)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
endmodule

bind walk1_tester wt_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TEST_ADDR(TEST_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .done_o(done_o), .err_mask_o(err_mask_o), .fail_valid_o(fail_valid_o),
    .fail_pattern_o(fail_pattern_o)
);

// File: tb/sim_walk1_tester.sv
module sim_walk1_tester;
    localparam int N = 8;
    localparam int AW = 8;
    localparam logic [AW-1:0] TADDR = 8'h5A;
    localparam int L = 2;
    localparam int RUN_EDGES = N * (L + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] addr;
    logic [N-1:0] wdata, rdata, mask, fpat;
    logic we, re, done, pass, fvld;

    always #2 clk = ~clk;

    walk1_tester #(.DATA_W(N), .ADDR_W(AW), .TEST_ADDR(TADDR), .RD_LAT(L)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mem_addr_o(addr),
        .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re), .mem_rdata_i(rdata),
        .done_o(done), .pass_o(pass), .err_mask_o(mask),
        .fail_valid_o(fvld), .fail_pattern_o(fpat)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fault model: stuck-low, stuck-high, wired-OR short group
    logic [N-1:0] f_s0 = '0, f_s1 = '0, f_sh = '0;
    function automatic logic [N-1:0] fault(input logic [N-1:0] w);
        logic [N-1:0] v;
        v = w;
        if ((w & f_sh) != '0) v = v | f_sh;
        return (v & ~f_s0) | f_s1;
    endfunction

    logic [N-1:0] store = '0;
    logic [N-1:0] rpipe [L];
    assign rdata = rpipe[L-1];
    initial for (int i = 0; i < L; i++) rpipe[i] = 8'hA5;

    always @(posedge clk) begin
        if (we) store <= fault(wdata);
        rpipe[0] <= re ? store : 8'hA5;
        for (int i = 1; i < L; i++) rpipe[i] <= rpipe[i-1];
    end

    // access monitor
    int wr_cnt = 0;
    int bad_addr = 0;
    int bad_order = 0;
    bit rd_pending = 1'b0;
    logic [N-1:0] wr_seq [N];
    always @(posedge clk) begin
        if (rst_n) begin
            if ((we || re) && addr != TADDR) bad_addr++;
            if (we && re) bad_order++;
            if (we) begin
                if (rd_pending) bad_order++;
                if (wr_cnt < N) wr_seq[wr_cnt] = wdata;
                wr_cnt++;
                rd_pending = 1'b1;
            end
            if (re) begin
                if (!rd_pending) bad_order++;
                rd_pending = 1'b0;
            end
        end
    end

    task automatic run(input logic [N-1:0] s0, input logic [N-1:0] s1,
                       input logic [N-1:0] sh, input bit mid_start);
        logic [N-1:0] e_mask, e_fpat, w, d;
        bit e_fvld;
        int e;
        f_s0 = s0; f_s1 = s1; f_sh = sh;
        e_mask = '0; e_fpat = '0; e_fvld = 1'b0;
        for (int k = 0; k < N; k++) begin
            w = N'(1) << k;
            d = w ^ fault(w);
            e_mask = e_mask | d;
            if (d != '0 && !e_fvld) begin
                e_fvld = 1'b1;
                e_fpat = w;
            end
        end
        @(negedge clk);
        wr_cnt = 0; bad_addr = 0; bad_order = 0; rd_pending = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mask == '0 && !fvld, "R9 mask/record cleared on start", {mask, 7'd0, fvld}, 0);
        e = 0;
        while (e < 200) begin
            @(negedge clk);
            e++;
            if (mid_start) start = (e == 10);
            if (done) break;
        end
        start = 1'b0;
        chk(e == RUN_EDGES, mid_start ? "R8 done timing with mid-run start" : "R7 done timing",
            e, RUN_EDGES);
        chk(pass == (e_mask == '0), "R7 pass at done", pass, e_mask == '0);
        chk(mask == e_mask, "R5 error mask", mask, e_mask);
        chk(fvld == e_fvld, "R6 fail valid", fvld, e_fvld);
        chk(fpat == e_fpat, "R6 first fail pattern", fpat, e_fpat);
        chk(wr_cnt == N, mid_start ? "R8 write count unchanged" : "R1 write count", wr_cnt, N);
        for (int k = 0; k < N; k++)
            chk(wr_seq[k] == (N'(1) << k), "R1 write pattern order", wr_seq[k], N'(1) << k);
        chk(bad_addr == 0, "R2 fixed address", bad_addr, 0);
        chk(bad_order == 0, "R3 write/read order", bad_order, 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        chk(mask == e_mask, "R4 mask holds after run, late read data ignored", mask, e_mask);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #5;
        chk(!we && !re && !done && mask == '0 && !fvld, "R10 state in reset",
            {we, re, done, fvld}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!we && !re && !done && mask == '0 && !fvld, "R10 state after reset",
            {we, re, done, fvld}, 0);
        run('0, '0, '0, 1'b0);
        for (int j = 0; j < N; j++) run(N'(1) << j, '0, '0, 1'b0);
        run('0, '0, '0, 1'b0);
        for (int j = 0; j < N; j++) run('0, N'(1) << j, '0, 1'b0);
        for (int j = 0; j < N - 1; j++) run('0, '0, N'(3) << j, j == 2);
        run('0, '0, '0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule